// File: doc/BRIEF.md
# Bus wake-up pattern detector

This block watches a sampled bus level (dominant or recessive) while the line driver is offline or the system is asleep. It recognizes a wake-up pattern made of three timed phases: a dominant phase, then a recessive phase, then a second dominant phase. Each phase has a minimum length, and the whole pattern must finish inside an overall time limit. A single long dominant level never wakes the system.

When a valid pattern is seen and detection is enabled, a sticky wake flag is set and the receive-data output is pulled low. The flag stays set until a write-one-to-clear strobe removes it. Releasing the flag also releases the receive-data line. All phase minimums and the time limit are parameters counted in clock cycles. An optional synchronizer of one or more stages sits in front of the detector.

Top module: `wkp_detector`

## Requirements
- R1: The wake flag becomes 1 at the clock edge that samples the T_DOM-th dominant cycle of the second dominant phase, delayed by the SYNC_STAGES synchronizer cycles, and not one cycle earlier. A valid pattern is at least T_DOM dominant cycles, then at least T_REC recessive cycles, then T_DOM dominant cycles. `bus_dom` is 1 for dominant and 0 for recessive.
- R2: If the first dominant phase lasts fewer than T_DOM cycles, the detector drops back to idle and the flag is not set.
- R3: If the recessive phase lasts fewer than T_REC cycles, the pattern is abandoned and the flag is not set.
- R4: If the second dominant phase ends before T_DOM cycles, the flag is not set.
- R5: Count the samples from the first dominant cycle up to the completing cycle, both included. The pattern is accepted only if that count is at most T_TO; otherwise the detector returns to idle. A single dominant level of any length never sets the flag.
- R6: After an abort, a new attempt starts only on a dominant sample that follows a recessive sample. A dominant level that is still present when the time limit runs out does not start a new attempt. A dominant edge that ends a recessive phase that was too short starts a new first phase at once.
- R7: While `det_en` is 0 the flag is never set, and any pattern in progress is abandoned.
- R8: The flag stays 1 until `wake_clr` is 1 at a clock edge. If a detection and a clear fall on the same edge, the flag stays set.
- R9: After reset the flag is 0. `rxd` is 0 whenever the flag is 1 and 1 whenever the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_en | input | 1 | Enables detection and capture of the wake event |
| bus_dom | input | 1 | Sampled bus level, 1 = dominant |
| wake_clr | input | 1 | Write-one-to-clear strobe for the wake flag |
| wake_flag | output | 1 | Sticky bus wake-up status |
| rxd | output | 1 | Receive-data output, low while the wake flag is set |

## Verification
On every cycle, the embedded properties check several invariants:
- the time counter never passes the limit while a pattern is in progress;
- each phase is entered only after the phase before it reached its minimum length;
- the flag rises only on a dominant sample, and only while detection is enabled;
- the flag holds until it is cleared, and a clear with no detection on the same edge removes it.

Only the bench scenarios can show the other behaviours:
- the exact cycle at which the flag appears;
- that the timeout boundary is accepted at exactly T_TO samples and refused at one more;
- that no new attempt starts while a dominant level is held past the timeout;
- that a detection on the same edge as a clear wins.

// File: rtl/wkp_pkg.sv
package wkp_pkg;
   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_DOM1 = 2'd1,
      WK_REC  = 2'd2,
      WK_DOM2 = 2'd3
   } wk_state_e;
endpackage

// File: rtl/wkp_sync.sv
module wkp_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sh;

   generate
      if (STAGES < 1) begin : g_bad_stages
         $error("wkp_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = sh[STAGES-1];
endmodule

// File: rtl/wkp_seq.sv
module wkp_seq
   import wkp_pkg::*;
#(
   parameter int T_DOM = 4,
   parameter int T_REC = 3,
   parameter int T_TO  = 14,
   localparam int CNT_W = $clog2(T_TO + 2)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic bus_dom,
   output logic hit
);
   localparam logic [CNT_W-1:0] TD_C  = CNT_W'(T_DOM);
   localparam logic [CNT_W-1:0] TR_C  = CNT_W'(T_REC);
   localparam logic [CNT_W-1:0] TO_C  = CNT_W'(T_TO);
   localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

   wk_state_e        st, st_n;
   logic [CNT_W-1:0] pc, pc_n, tc, tc_n;
   logic             prev_dom, rise, abort;
   logic [CNT_W-1:0] pc_inc, tc_inc;

   assign rise   = bus_dom & ~prev_dom;
   assign pc_inc = pc + ONE_C;
   assign tc_inc = tc + ONE_C;

   always_comb begin
      st_n  = st;
      pc_n  = pc;
      tc_n  = tc;
      hit   = 1'b0;
      abort = 1'b0;
      if (!en) begin
         st_n = WK_IDLE;
         pc_n = '0;
         tc_n = '0;
      end else if (st == WK_IDLE) begin
         if (rise) begin
            st_n = WK_DOM1;
            pc_n = ONE_C;
            tc_n = ONE_C;
         end
      end else if (tc_inc > TO_C) begin
         abort = 1'b1;
      end else begin
         tc_n = tc_inc;
         unique case (st)
            WK_DOM1: begin
               if (bus_dom)          pc_n = pc_inc;
               else if (pc >= TD_C) begin
                  st_n = WK_REC;
                  pc_n = ONE_C;
               end else              abort = 1'b1;
            end
            WK_REC: begin
               if (!bus_dom)         pc_n = pc_inc;
               else if (pc >= TR_C) begin
                  if (ONE_C >= TD_C) begin
                     hit  = 1'b1;
                     st_n = WK_IDLE;
                  end else begin
                     st_n = WK_DOM2;
                     pc_n = ONE_C;
                  end
               end else              abort = 1'b1;
            end
            WK_DOM2: begin
               if (!bus_dom)             abort = 1'b1;
               else if (pc_inc >= TD_C) begin
                  hit  = 1'b1;
                  st_n = WK_IDLE;
               end else                  pc_n = pc_inc;
            end
            default: st_n = WK_IDLE;
         endcase
         if (hit) begin
            pc_n = '0;
            tc_n = '0;
         end
      end
      if (abort) begin
         if (rise) begin
            st_n = WK_DOM1;
            pc_n = ONE_C;
            tc_n = ONE_C;
         end else begin
            st_n = WK_IDLE;
            pc_n = '0;
            tc_n = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= WK_IDLE;
         pc       <= '0;
         tc       <= '0;
         prev_dom <= 1'b1;
      end else begin
         st       <= st_n;
         pc       <= pc_n;
         tc       <= tc_n;
         prev_dom <= bus_dom;
      end
   end

   a_r5_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st != WK_IDLE) |-> (tc <= TO_C));
   a_r2_rec_after_long_dom: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WK_REC && $past(st) == WK_DOM1) |-> ($past(pc) >= TD_C));
   a_r3_dom2_after_long_rec: assert property (@(posedge clk) disable iff (!rst_n)
      (st == WK_DOM2 && $past(st) == WK_REC) |-> ($past(pc) >= TR_C));
endmodule

// File: rtl/wkp_flag.sv
module wkp_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);
endmodule

// File: rtl/wkp_detector.sv
module wkp_detector #(
   parameter int T_DOM       = 50,
   parameter int T_REC       = 50,
   parameter int T_TO        = 10000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic det_en,
   input  logic bus_dom,
   input  logic wake_clr,
   output logic wake_flag,
   output logic rxd
);
   generate
      if (T_DOM < 1 || T_REC < 1) begin : g_bad_phase
         $error("wkp_detector: phase minimums must be at least 1");
      end
      if (T_TO < 2 * T_DOM + T_REC) begin : g_bad_window
         $error("wkp_detector: T_TO too short for any valid pattern");
      end
   endgenerate

   logic bus_s, hit;

   wkp_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(bus_dom), .q(bus_s)
   );

   wkp_seq #(.T_DOM(T_DOM), .T_REC(T_REC), .T_TO(T_TO)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(det_en), .bus_dom(bus_s), .hit(hit)
   );

   wkp_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(hit), .clr(wake_clr), .flag(wake_flag)
   );

   assign rxd = ~wake_flag;

   a_r7_set_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag) |-> $past(det_en));
   a_r1_set_on_dom: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag) |-> $past(bus_s));
endmodule

// File: tb/tb_wkp_detector.sv
module tb_wkp_detector;
   localparam int TD = 4, TR = 3, TO = 14, SY = 2;

   logic clk = 1'b0, rst_n = 1'b0, det_en = 1'b1, bus_dom = 1'b0, wake_clr = 1'b0;
   logic wake_flag, rxd;
   int errors = 0, checks = 0;
   bit done = 1'b0;
   bit   exp_q[$];
   string tag_q[$];
   event chk_ev;

   always #5 clk = ~clk;

   wkp_detector #(.T_DOM(TD), .T_REC(TR), .T_TO(TO), .SYNC_STAGES(SY)) dut (
      .clk(clk), .rst_n(rst_n), .det_en(det_en), .bus_dom(bus_dom),
      .wake_clr(wake_clr), .wake_flag(wake_flag), .rxd(rxd)
   );

   // monitor: pops expected items and compares against the ports
   initial forever begin
      @(chk_ev);
      #1;
      while (exp_q.size() > 0) begin
         bit e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (wake_flag !== e) begin
            errors++;
            $display("FAIL %s: wake_flag=%0b expected %0b", t, wake_flag, e);
         end
         checks++;
         if (rxd !== !e) begin
            errors++;
            $display("FAIL %s (R9): rxd=%0b expected %0b", t, rxd, !e);
         end
      end
   end

   task automatic expect_flag(input bit e, input string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      -> chk_ev;
      #2;
   endtask

   task automatic drive(input bit v, input int n);
      repeat (n) begin
         bus_dom = v;
         @(negedge clk);
      end
   endtask

   task automatic gap();
      drive(1'b0, 20);
   endtask

   task automatic pat(input int d1, input int r, input int d2);
      gap();
      drive(1'b1, d1);
      drive(1'b0, r);
      drive(1'b1, d2);
      drive(1'b0, 4);
   endtask

   task automatic clear();
      wake_clr = 1'b1;
      @(negedge clk);
      wake_clr = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      expect_flag(1'b0, "R9 reset state");

      // R1 exact timing
      gap();
      drive(1'b1, TD);
      drive(1'b0, TR);
      drive(1'b1, TD - 1 + SY);
      expect_flag(1'b0, "R1 one cycle before set");
      drive(1'b1, 1);
      expect_flag(1'b1, "R1 set on completing sample");
      drive(1'b0, 30);
      expect_flag(1'b1, "R8 flag sticky");
      clear();
      expect_flag(1'b0, "R8 cleared by strobe");

      pat(TD - 1, TR, TD);
      expect_flag(1'b0, "R2 short first dominant");
      pat(TD, TR - 1, TD);
      expect_flag(1'b0, "R3 short recessive");
      pat(TD, TR, TD - 1);
      expect_flag(1'b0, "R4 short second dominant");

      pat(TO - TR - TD, TR, TD);
      expect_flag(1'b1, "R5 pattern exactly at limit");
      clear();
      pat(TO - TR - TD + 1, TR, TD);
      expect_flag(1'b0, "R5 pattern one over limit");
      gap();
      drive(1'b1, 60);
      drive(1'b0, 4);
      expect_flag(1'b0, "R5 single long dominant");

      // R6: dominant held past timeout must not rearm
      gap();
      drive(1'b1, 20);
      drive(1'b0, TR);
      drive(1'b1, TD);
      drive(1'b0, 4);
      expect_flag(1'b0, "R6 no rearm without recessive edge");
      // R6: edge ending a short recessive restarts
      gap();
      drive(1'b1, TD);
      drive(1'b0, TR - 1);
      drive(1'b1, TD);
      drive(1'b0, TR);
      drive(1'b1, TD);
      drive(1'b0, 4);
      expect_flag(1'b1, "R6 restart on edge after short recessive");
      clear();
      expect_flag(1'b0, "R8 clear after restart case");

      det_en = 1'b0;
      pat(TD, TR, TD);
      expect_flag(1'b0, "R7 detection disabled");
      det_en = 1'b1;
      gap();
      drive(1'b1, TD);
      drive(1'b0, TR);
      det_en = 1'b0;
      drive(1'b1, 1);
      det_en = 1'b1;
      drive(1'b1, TD - 1);
      drive(1'b0, 4);
      expect_flag(1'b0, "R7 enable dropped mid pattern");

      pat(TD, TR, TD);
      expect_flag(1'b1, "R1 plain valid pattern");
      gap();
      drive(1'b1, TD);
      drive(1'b0, TR);
      drive(1'b1, TD - 1 + SY);
      wake_clr = 1'b1;
      drive(1'b1, 1);
      wake_clr = 1'b0;
      drive(1'b0, 4);
      expect_flag(1'b1, "R8 set wins over clear");
      clear();
      expect_flag(1'b0, "R8 final clear");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule